// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is a synchronous master that fetches one conversion from a 12-bit serial-output analog-to-digital converter over three wires: an active-low chip select, a serial clock it generates itself, and a data line coming back from the converter. A one-cycle `start` pulse begins a frame. The controller lowers chip select and waits a set-up interval. It then toggles the serial clock with equal high and low phases, each a whole number of system clock cycles long. Data is captured on every rising edge of the serial clock, because the converter only changes its output on falling edges.

The converter uses its first two rising edges to sample its input. After that it sends a zero marker bit, then the 12 result bits with the most significant bit first. It then repeats bits 1 to 11 with the least significant bit first, sharing bit 0 with the first word. The controller checks the marker bit. When the echo check is requested at start, it also clocks in the repeated bits and compares them with the first word. It then raises chip select and keeps it high for a minimum interval before it reports the result with a one-cycle `done` pulse and an error flag. `busy` covers the whole transaction, including that interval.

All timing is set in system clock cycles by parameters. The defaults suit a 200 MHz system clock: a 320 ns half period, a 100 ns set-up time and a 625 ns chip-select high time.

Top module: `adc_read_ctrl`

## Requirements
- R1: Reset state. During and after reset, with no start, `cs_n` is 1, `sclk` is 0, and `busy`, `done`, `err` and `result` are 0.
- R2: A start in idle drives `cs_n` low. `sclk` stays low for exactly SETUP_CYCLES system cycles after `cs_n` falls, and then the first rising edge occurs.
- R3: While `cs_n` is low, every high phase and every low phase of `sclk` lasts exactly HALF_PERIOD_CYCLES system cycles. `sclk` is 0 whenever `cs_n` is 1.
- R4: A frame has 15 rising `sclk` edges when the echo check is off and 26 when it is on. The echo setting is taken from `echo_chk` in the cycle `start` is accepted.
- R5: `sdi` is sampled on rising edges. Rise 3 carries the marker bit. Rises 4 to 15 carry result bits 11 down to 0, and these form `result`. Codes 0 and 4095 pass unchanged.
- R6: If the marker bit read at rise 3 is 1, `err` is 1 for that conversion.
- R7: With the echo check on, rises 16 to 26 carry result bits 1 to 11 in that order. Any difference from the first word sets `err`.
- R8: With the echo check off, the bits after rise 15 are ignored, and `err` depends only on the marker bit.
- R9: After the last rising edge and one more high phase, `sclk` falls and `cs_n` rises together. `cs_n` then stays high for CS_HIGH_CYCLES cycles before `done` pulses for one cycle, and `busy` falls in that same cycle. `busy` is 1 for as long as `cs_n` is low.
- R10: `result` and `err` change only in the cycle where `done` is 1, and they hold their values until the next `done`.
- R11: A `start` pulse while `busy` is 1 has no effect. The running frame completes normally, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a conversion read |
| echo_chk | input | 1 | Enables the reversed repeat comparison, sampled with start |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High from accepted start until the chip-select high time ends |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 12 | Converted code, held until the next done |
| err | output | 1 | Marker bit or echo mismatch detected |

## Verification
The bench builds the controller with HALF_PERIOD_CYCLES=3, SETUP_CYCLES=2 and CS_HIGH_CYCLES=4. A full echo frame then takes under 200 system cycles. This allows dozens of frames to run, covering directed codes, the marker-bit fault, echo corruption at both ends of the echo, and random codes with random echo settings. The short but unequal settings make the bench's cycle counts tell set-up time, half period and chip-select high time apart. A bench model of the converter drives `sdi` on each falling edge of `sclk`.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int ADC_BITS    = 12;
    localparam int MARK_RISE   = 3;
    localparam int RISES_PLAIN = MARK_RISE + ADC_BITS;
    localparam int RISES_ECHO  = RISES_PLAIN + ADC_BITS - 1;
    localparam int CNT_W       = $clog2(RISES_ECHO + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_CSHOLD
    } rd_state_e;

    typedef struct packed {
        logic [ADC_BITS-1:0] word;
        logic                mark_bad;
        logic                echo_bad;
    } rd_capture_t;

    function automatic logic [CNT_W-1:0] final_rise(input logic echo_on);
        return echo_on ? CNT_W'(RISES_ECHO) : CNT_W'(RISES_PLAIN);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic [CNT_W-1:0] rise_idx,
    input  logic             din,
    output rd_capture_t      cap
);
    localparam int LAST_WORD = MARK_RISE + ADC_BITS;

    logic [ADC_BITS-1:0] word_q;
    logic [ADC_BITS-2:0] echo_q;
    logic                mark_q;
    logic [ADC_BITS-2:0] diff;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word_q <= '0;
            echo_q <= '0;
            mark_q <= 1'b0;
        end else if (sample) begin
            if (rise_idx == CNT_W'(MARK_RISE)) begin
                mark_q <= din;
            end else if (rise_idx > CNT_W'(MARK_RISE) && rise_idx <= CNT_W'(LAST_WORD)) begin
                word_q <= {word_q[ADC_BITS-2:0], din};
            end else if (rise_idx > CNT_W'(LAST_WORD)) begin
                echo_q <= {din, echo_q[ADC_BITS-2:1]};
            end
        end
    end

    // echo_q[k] holds the repeated copy of word bit k+1
    for (genvar k = 0; k < ADC_BITS - 1; k++) begin : g_cmp
        assign diff[k] = echo_q[k] ^ word_q[k+1];
    end

    assign cap.word     = word_q;
    assign cap.mark_bad = mark_q;
    assign cap.echo_bad = |diff;

    // R4
    rise_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sample |-> (rise_idx != '0 && rise_idx <= CNT_W'(RISES_ECHO)));

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int HALF_PERIOD_CYCLES = 64,
    parameter int SETUP_CYCLES       = 20,
    parameter int CS_HIGH_CYCLES     = 125
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                echo_chk,
    input  logic                sdi,
    output logic                cs_n,
    output logic                sclk,
    output logic                busy,
    output logic                done,
    output logic [ADC_BITS-1:0] result,
    output logic                err
);
    localparam int TMAX   = max3(HALF_PERIOD_CYCLES, SETUP_CYCLES, CS_HIGH_CYCLES);
    localparam int TW     = $clog2(TMAX + 1);
    localparam int RW     = $clog2(TMAX + 2) + 1;
    localparam int MINRISE = min2(HALF_PERIOD_CYCLES, SETUP_CYCLES);

    localparam logic [TW-1:0] LD_HALF  = TW'(HALF_PERIOD_CYCLES - 1);
    localparam logic [TW-1:0] LD_SETUP = TW'(SETUP_CYCLES - 1);
    localparam logic [TW-1:0] LD_CSH   = TW'(CS_HIGH_CYCLES - 1);

    rd_state_e        state;
    logic [CNT_W-1:0] rise_cnt;
    logic             echo_q;
    logic             t_load;
    logic [TW-1:0]    t_val;
    logic             t_exp;
    logic             smp;
    logic [CNT_W-1:0] smp_idx;
    logic             last_rise;
    rd_capture_t      cap;

    assign last_rise = (rise_cnt == final_rise(echo_q));

    always_comb begin
        t_load = 1'b0;
        t_val  = LD_HALF;
        case (state)
            ST_IDLE: begin
                t_load = start;
                t_val  = LD_SETUP;
            end
            ST_SETUP, ST_LOW: begin
                t_load = t_exp;
                t_val  = LD_HALF;
            end
            ST_HIGH: begin
                t_load = t_exp;
                t_val  = last_rise ? LD_CSH : LD_HALF;
            end
            default: begin
                t_load = 1'b0;
                t_val  = LD_HALF;
            end
        endcase
    end

    assign smp     = (state == ST_SETUP || state == ST_LOW) && t_exp;
    assign smp_idx = (state == ST_SETUP) ? CNT_W'(1) : rise_cnt + 1'b1;

    adc_rd_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    adc_rd_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (state == ST_IDLE && start),
        .sample   (smp),
        .rise_idx (smp_idx),
        .din      (sdi),
        .cap      (cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            rise_cnt <= '0;
            echo_q   <= 1'b0;
            result   <= '0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cs_n     <= 1'b0;
                        busy     <= 1'b1;
                        echo_q   <= echo_chk;
                        rise_cnt <= '0;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_LOW: begin
                    if (t_exp) begin
                        sclk     <= 1'b1;
                        rise_cnt <= smp_idx;
                        state    <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (t_exp) begin
                        sclk <= 1'b0;
                        if (last_rise) begin
                            cs_n  <= 1'b1;
                            state <= ST_CSHOLD;
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                end
                ST_CSHOLD: begin
                    if (t_exp) begin
                        busy   <= 1'b0;
                        done   <= 1'b1;
                        result <= cap.word;
                        err    <= cap.mark_bad | (echo_q & cap.echo_bad);
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Run-length monitor of the bus lines for the timing checks
    logic          sclk_d, cs_d;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
            run    <= RW'(TMAX + 1);
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
            if (sclk != sclk_d || cs_n != cs_d) begin
                run <= RW'(1);
            end else if (run < RW'(TMAX + 1)) begin
                run <= run + 1'b1;
            end
        end
    end

    // R3
    high_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_d && !sclk) |-> run >= RW'(HALF_PERIOD_CYCLES));

    // R2
    rise_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_d && sclk) |-> run >= RW'(MINRISE));

    // R9
    cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_d && !cs_n) |-> run >= RW'(CS_HIGH_CYCLES));

    // R3
    sclk_framed_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && cs_n && $past(busy)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(err)));

endmodule

// File: tb/test_adc_read_ctrl.sv
module test_adc_read_ctrl;
    localparam int HALF  = 3;
    localparam int SETUP = 2;
    localparam int CSH   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        echo_chk = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_n, sclk, busy, done, err;
    logic [11:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_read_ctrl #(
        .HALF_PERIOD_CYCLES (HALF),
        .SETUP_CYCLES       (SETUP),
        .CS_HIGH_CYCLES     (CSH)
    ) i_adc_read_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .echo_chk (echo_chk),
        .sdi      (sdi),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .err      (err)
    );

    // Converter model state
    logic [11:0] m_code = '0;
    logic        m_bad_mark = 1'b0;
    int          m_flip = 0;
    logic        ps = 1'b0, pc = 1'b1;
    int          run = 0, rises = 0, setup_len = 0, cs_hi_len = 0;
    int          min_high = 0, max_high = 0, min_low = 0, max_low = 0;
    int          done_cnt = 0, cap_run = 0;
    logic [11:0] cap_res = '0;
    logic        cap_err = 1'b0;
    logic        busy_bad = 1'b0;

    function automatic logic model_bit(input int r);
        if (r == 2) return m_bad_mark;
        if (r >= 3 && r <= 14) return m_code[14 - r];
        if (r >= 15 && r <= 25) return m_code[r - 14] ^ ((r - 14) == m_flip);
        return 1'b0;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (sclk == ps && cs_n == pc) begin
                run++;
            end else begin
                if (pc && !cs_n) begin
                    cs_hi_len = run;
                    rises = 0;
                    sdi = 1'b0;
                end
                if (!ps && sclk) begin
                    if (rises == 0) setup_len = run;
                    else begin
                        if (run < min_low) min_low = run;
                        if (run > max_low) max_low = run;
                    end
                    rises++;
                end
                if (ps && !sclk) begin
                    if (run < min_high) min_high = run;
                    if (run > max_high) max_high = run;
                    sdi = model_bit(rises);
                end
                run = 1;
            end
            if (!cs_n && !busy) busy_bad = 1'b1;
            if (done) begin
                done_cnt++;
                cap_res = result;
                cap_err = err;
                cap_run = run;
            end
            ps = sclk;
            pc = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic frame(input logic [11:0] code, input bit echo, input bit bad_mark,
                         input int flip, input bit extra_start);
        int  wait_cyc;
        bit  exp_err;
        logic [11:0] held;
        m_code = code;
        m_bad_mark = bad_mark;
        m_flip = flip;
        min_high = 1000; max_high = 0; min_low = 1000; max_low = 0;
        done_cnt = 0;
        busy_bad = 1'b0;
        @(negedge clk);
        start = 1'b1;
        echo_chk = echo;
        @(negedge clk);
        start = 1'b0;
        echo_chk = ~echo;
        check(busy && !cs_n, "R2 cs_n low and busy after start", int'(busy), 1);
        wait_cyc = 0;
        while (done_cnt == 0 && wait_cyc < 1000) begin
            @(negedge clk);
            wait_cyc++;
            if (extra_start && wait_cyc == 20) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        check(done_cnt == 1, "R9 done seen", done_cnt, 1);
        exp_err = bad_mark | (echo && flip >= 1 && flip <= 11);
        check(cap_res == code, "R5 result word", int'(cap_res), int'(code));
        if (bad_mark) check(cap_err == exp_err, "R6 marker error", int'(cap_err), int'(exp_err));
        else if (echo) check(cap_err == exp_err, "R7 echo compare", int'(cap_err), int'(exp_err));
        else check(cap_err == exp_err, "R8 echo ignored", int'(cap_err), int'(exp_err));
        check(rises == (echo ? 26 : 15), "R4 rising edge count", rises, echo ? 26 : 15);
        check(setup_len == SETUP, "R2 setup length", setup_len, SETUP);
        check(min_high == HALF && max_high == HALF, "R3 high phase", min_high, HALF);
        check(min_low == HALF && max_low == HALF, "R3 low phase", max_low, HALF);
        check(cs_hi_len >= CSH, "R9 cs high before frame", cs_hi_len, CSH);
        check(cap_run == CSH + 1, "R9 cs high to done", cap_run, CSH + 1);
        check(!busy_bad, "R9 busy while cs low", int'(busy_bad), 0);
        held = result;
        repeat (6) @(negedge clk);
        check(done_cnt == 1, "R9 done single pulse", done_cnt, 1);
        check(result == held && err == cap_err, "R10 result held", int'(result), int'(held));
        if (extra_start)
            check(cs_n && !busy, "R11 start while busy ignored", int'(cs_n), 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check(cs_n && !sclk && !busy && !done, "R1 reset outputs", int'(cs_n), 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_n && !sclk && !busy && !done && result == 0 && !err,
              "R1 idle after reset", int'(result), 0);

        frame(12'h000, 1'b0, 1'b0, 0, 1'b0);
        frame(12'hFFF, 1'b1, 1'b0, 0, 1'b0);
        frame(12'hA5A, 1'b1, 1'b0, 0, 1'b0);
        frame(12'h3C7, 1'b0, 1'b1, 0, 1'b0);
        frame(12'h801, 1'b1, 1'b0, 1, 1'b0);
        frame(12'h801, 1'b1, 1'b0, 11, 1'b0);
        frame(12'h5A5, 1'b0, 1'b0, 6, 1'b0);
        frame(12'h123, 1'b1, 1'b1, 0, 1'b0);
        frame(12'h9E4, 1'b1, 1'b0, 0, 1'b1);
        frame(12'h9E4, 1'b0, 1'b0, 0, 1'b1);

        for (int i = 0; i < 30; i++) begin
            logic [11:0] c;
            bit e, bm;
            int f;
            c  = 12'($urandom);
            e  = 1'($urandom);
            bm = ($urandom % 8) == 0;
            f  = (($urandom % 3) == 0) ? int'($urandom % 11) + 1 : 0;
            frame(c, e, bm, f, 1'b0);
        end

        finish_run();
    end

endmodule